// File: doc/BRIEF.md
# Byte Program Sequencer

This block runs on the host side and writes a run of bytes into a reprogrammable memory, one byte at a time. A start strobe hands it a first address and a byte count. It raises the high-voltage enable, then takes each data byte from a valid/ready stream. For every byte it writes the set-up code and then the address and data, waits out the program pulse, and writes the verify code. After a short settle time it reads the cell back and compares the result with the byte it wrote.

When a read-back matches, the block moves to the next address. When it does not match, the same byte is pulsed and verified again. There is a per-byte limit of pulses. When that limit runs out, the run aborts and the block reports the address that failed. At the end of every run, whether it passed or failed, the high voltage is dropped and a read command is written in the same cycle.

Stream rules: `src_ready` is high only while the block is waiting for the next byte to program. A byte is taken on a clock edge where `src_valid` and `src_ready` are both high. The source may raise or drop `src_valid` on any cycle. While the block is pulsing or verifying a byte, the source is held off. Bytes beyond the requested count are never taken.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `src_ready`, `mem_vpp_en`, `mem_we` and `mem_rd` are all 0.
- R2: A `start` while idle captures `start_addr` and `byte_count`. `mem_vpp_en` is raised before the first bus write. A `start` while busy is ignored.
- R3: Each program attempt is two writes on consecutive cycles. The first carries data 8'h40. The second carries the target address on `mem_addr` and the data byte on `mem_wdata`.
- R4: The verify code 8'hC0 is written exactly PULSE_CYC+1 cycles after the address/data write. The read strobe `mem_rd` follows it exactly VERIFY_CYC+1 cycles later. `mem_rdata` is sampled on the cycle after the strobe.
- R5: When the read-back equals the data byte, the next byte goes to address+1, wrapping at 2^ADDR_W. When it differs, the same byte is set up, pulsed and verified again at the same address.
- R6: A byte gets at most MAX_PULSES program writes. The pulse counter restarts for each new byte. If the read-back still differs after the last allowed pulse, the run aborts with `error`=1 and `fail_addr` set to that address. A byte that needs exactly MAX_PULSES pulses passes.
- R7: `src_ready` is high only while waiting for the next byte. Exactly one stream byte is taken per byte programmed, and a new byte is taken only after the previous one verified.
- R8: A run ends with one cycle in which `done`=1, `mem_vpp_en`=0, `mem_we`=1 and `mem_wdata`=8'h00.
- R9: `error` and `fail_addr` hold their values after an aborted run until the next accepted `start`, which clears `error`.
- R10: A `byte_count` of 0 issues no program write and takes no stream byte, but still ends as in R8.
- R11: No write other than data 8'h00 is ever issued while `mem_vpp_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only while idle) |
| start_addr | input | ADDR_W | First address to program |
| byte_count | input | CNT_W | Number of bytes to program |
| src_valid | input | 1 | Stream byte available |
| src_data | input | 8 | Stream byte |
| src_ready | output | 1 | Block can take a stream byte |
| mem_vpp_en | output | 1 | High-voltage enable to the memory |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Command or data written |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run aborted on pulse limit |
| fail_addr | output | ADDR_W | Address that exhausted its pulses |

## Verification
The bench uses a memory model in which each cell needs a chosen number of pulses before it takes its data. It targets a byte that needs exactly the pulse limit and one that needs one more. A design off by one in its tally would either fail the first or fire a 26th pulse on the second. Runs whose address wraps past the top catch a walker that saturates or reloads. A zero-count run catches a design that programs one stray byte. A `start` issued mid-run catches a design that reloads its address and programs the wrong cells. The stream source stalls irregularly, so a design that takes bytes early, before verify, or past the count shows a wrong accepted-byte total.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_READ   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_SETUP  = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_VERIFY = 8'hC0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VPP_ON,
    ST_FETCH,
    ST_SETUP,
    ST_PROG,
    ST_PULSE,
    ST_VCMD,
    ST_VWAIT,
    ST_VREAD,
    ST_CHECK,
    ST_FINISH
  } bps_state_t;
endpackage

// File: rtl/bps_interval_timer.sv
module bps_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val - W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

  // R4: a wait is never restarted while one is still running
  a_r4_no_reload_midwait: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired);
endmodule

// File: rtl/bps_pulse_tally.sv
module bps_pulse_tally #(
  parameter int MAX_PULSES = 25,
  localparam int TW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + TW'(1);
  end

  assign at_limit = (cnt_q == TW'(MAX_PULSES));

  // R6: no pulse is issued once the limit is used up
  a_r6_no_extra_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);
  a_r6_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAX_PULSES));
endmodule

// File: rtl/bps_addr_walker.sv
module bps_addr_walker #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              empty
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain_q <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain_q <= load_cnt;
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_W'(1);
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign empty = (remain_q == '0);

  // R5: the walker never advances past the requested count
  a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty);
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CNT_W      = 18,
  parameter int PULSE_CYC  = 2000,
  parameter int VERIFY_CYC = 1200,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              src_ready,
  output logic              mem_vpp_en,
  output logic              mem_we,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int LONGEST = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
  localparam int TMR_W   = $clog2(LONGEST + 1);

  bps_state_t st_q, st_d;
  logic [BYTE_W-1:0] data_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              wk_load, wk_step, wk_empty;
  logic              tm_load, tm_exp;
  logic [TMR_W-1:0]  tm_val;
  logic              ty_clr, ty_inc, ty_at_lim;
  logic              take, match, give_up;

  bps_addr_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) walker_i (
    .clk(clk), .rst_n(rst_n), .load(wk_load), .load_addr(start_addr),
    .load_cnt(byte_count), .step(wk_step), .cur_addr(cur_addr), .empty(wk_empty)
  );

  bps_interval_timer #(.W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .expired(tm_exp)
  );

  bps_pulse_tally #(.MAX_PULSES(MAX_PULSES)) tally_i (
    .clk(clk), .rst_n(rst_n), .clr(ty_clr), .inc(ty_inc), .at_limit(ty_at_lim)
  );

  assign src_ready = (st_q == ST_FETCH) && !wk_empty;
  assign take      = src_ready && src_valid;
  assign match     = (mem_rdata == data_q);
  assign give_up   = (st_q == ST_CHECK) && !match && ty_at_lim;

  always_comb begin
    st_d    = st_q;
    wk_load = 1'b0;
    wk_step = 1'b0;
    tm_load = 1'b0;
    tm_val  = TMR_W'(PULSE_CYC);
    ty_clr  = 1'b0;
    ty_inc  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        wk_load = 1'b1;
        st_d    = ST_VPP_ON;
      end
      ST_VPP_ON: st_d = ST_FETCH;
      ST_FETCH: begin
        if (wk_empty) st_d = ST_FINISH;
        else if (src_valid) begin
          ty_clr = 1'b1;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: st_d = ST_PROG;
      ST_PROG: begin
        ty_inc  = 1'b1;
        tm_load = 1'b1;
        st_d    = ST_PULSE;
      end
      ST_PULSE: if (tm_exp) st_d = ST_VCMD;
      ST_VCMD: begin
        tm_load = 1'b1;
        tm_val  = TMR_W'(VERIFY_CYC);
        st_d    = ST_VWAIT;
      end
      ST_VWAIT: if (tm_exp) st_d = ST_VREAD;
      ST_VREAD: st_d = ST_CHECK;
      ST_CHECK: begin
        if (match) begin
          wk_step = 1'b1;
          st_d    = ST_FETCH;
        end else if (ty_at_lim) st_d = ST_FINISH;
        else st_d = ST_SETUP;
      end
      ST_FINISH: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_wdata = CMD_READ;
    unique case (st_q)
      ST_SETUP: mem_wdata = CMD_SETUP;
      ST_PROG:  mem_wdata = data_q;
      ST_VCMD:  mem_wdata = CMD_VERIFY;
      default:  mem_wdata = CMD_READ;
    endcase
  end

  assign mem_vpp_en = (st_q != ST_IDLE) && (st_q != ST_FINISH);
  assign mem_we     = (st_q == ST_SETUP) || (st_q == ST_PROG) ||
                      (st_q == ST_VCMD)  || (st_q == ST_FINISH);
  assign mem_rd     = (st_q == ST_VREAD);
  assign mem_addr   = cur_addr;
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      data_q    <= '0;
      error     <= 1'b0;
      fail_addr <= '0;
    end else begin
      st_q <= st_d;
      if (take) data_q <= src_data;
      if (st_q == ST_IDLE && start) error <= 1'b0;
      else if (give_up) begin
        error     <= 1'b1;
        fail_addr <= cur_addr;
      end
    end
  end

  // R11: nothing but the read command is written with high voltage off
  a_r11_we_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wdata != CMD_READ) |-> mem_vpp_en);
  // R7: the stream is only opened while high voltage is on
  a_r7_ready_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> mem_vpp_en);
  a_r7_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !src_ready);
  // R8: completion is a single-cycle pulse followed by idle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R9: a reported failure stays put until a new run is accepted
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !(start && !busy)) |=> (error && $stable(fail_addr)));
  // R3: read and write strobes never coincide
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_rd));
endmodule

// File: tb/byte_prog_seq_tb_top.sv
module byte_prog_seq_tb_top;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int P  = 4;
  localparam int V  = 3;
  localparam int MP = 25;
  localparam int NV = 6;
  // fields: [31:24] start addr, [23:16] count, [15:8] hard addr, [7:0] pulses it needs
  localparam logic [31:0] VECS [0:NV-1] = '{
    32'h0A_04_0C_07,
    32'h40_03_41_19,
    32'h80_05_82_1A,
    32'hFE_04_00_03,
    32'h20_00_20_30,
    32'h30_02_30_28
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic src_valid = 1'b0;
  logic [7:0] src_data = '0;
  logic src_ready, mem_vpp_en, mem_we, mem_rd, busy, done, error;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'hFF;

  int checks = 0, fails = 0;
  int cyc = 0, fcyc = 0;
  logic [7:0] mem [0:255];
  int pcount [0:255];
  int acc_cnt = 0, prog_total = 0, seq_bad = 0, gap_bad = 0, vpp_bad = 0;
  int last_prog = 0, last_vc = 0;
  bit armed = 0, vmode = 0, feed_on = 0;
  int g_start = 0, g_hard = 0, g_need = 1;

  always #2.5 clk = ~clk;

  byte_prog_seq #(.ADDR_W(AW), .CNT_W(CW), .PULSE_CYC(P), .VERIFY_CYC(V),
                  .MAX_PULSES(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .mem_vpp_en(mem_vpp_en), .mem_we(mem_we),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .error(error),
    .fail_addr(fail_addr)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a % 256) * 37 + 90);
  endfunction

  function automatic int need_of(input int a);
    if (a == g_hard) return g_need;
    return (a % 4 == 3) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // memory model: a cell takes its data once it has seen enough pulses
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_we && mem_wdata != 8'h00 && !mem_vpp_en) vpp_bad++;
      if (armed) begin
        if (mem_we) begin
          pcount[mem_addr]++;
          prog_total++;
          if (pcount[mem_addr] >= need_of(int'(mem_addr)))
            mem[mem_addr] = mem[mem_addr] & mem_wdata;
          last_prog = cyc;
          vmode = 0;
        end else seq_bad++;
        armed = 0;
      end else if (mem_we) begin
        if (mem_wdata == 8'h40) armed = 1;
        else if (mem_wdata == 8'hC0) begin
          if (cyc - last_prog != P + 1) gap_bad++;
          vmode = 1;
          last_vc = cyc;
        end else vmode = 0;
      end
      if (mem_rd) begin
        if (!vmode) seq_bad++;
        if (cyc - last_vc != V + 1) gap_bad++;
        mem_rdata <= mem[mem_addr];
      end
      if (src_valid && src_ready) acc_cnt++;
    end
  end

  // stream source with irregular stalls
  initial begin
    forever begin
      @(negedge clk);
      fcyc++;
      src_valid = feed_on && (fcyc % 3 != 0);
      src_data  = pat(g_start + acc_cnt);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic clear_model();
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'hFF;
      pcount[a] = 0;
    end
    acc_cnt = 0; prog_total = 0; seq_bad = 0; gap_bad = 0; vpp_bad = 0;
  endtask

  task automatic launch(input int sa, input int cnt);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(sa); byte_count = CW'(cnt);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic run_vec(input int sa, input int cnt, input int hard, input int nd);
    bit seen, exp_err;
    int exp_fail, exp_acc, hard_pos, mism;
    g_start = sa; g_hard = hard; g_need = nd;
    clear_model();
    exp_err = 0; exp_fail = 0; exp_acc = cnt; hard_pos = -1;
    for (int i = 0; i < cnt; i++) begin
      int a;
      a = (sa + i) % 256;
      if (a == hard) hard_pos = i;
      if (need_of(a) > MP) begin
        exp_err = 1; exp_fail = a; exp_acc = i + 1;
        break;
      end
    end
    feed_on = 1;
    launch(sa, cnt);
    chk(busy == 1'b1 && error == 1'b0, "R9 start clears error", int'(error), 0);
    wait_done(seen);
    chk(seen, "R8 run completes", int'(seen), 1);
    chk(!mem_vpp_en && mem_we && mem_wdata == 8'h00, "R8 end cycle vpp off + 00h",
        int'({mem_vpp_en, mem_we, mem_wdata}), 32'h100);
    feed_on = 0;
    @(negedge clk);
    chk(error == exp_err, "R6 error flag", int'(error), int'(exp_err));
    if (exp_err) chk(fail_addr == AW'(exp_fail), "R6 fail address", int'(fail_addr), exp_fail);
    chk(acc_cnt == exp_acc, "R7 stream bytes taken", acc_cnt, exp_acc);
    chk(seq_bad == 0, "R3 setup/program pairing", seq_bad, 0);
    chk(gap_bad == 0, "R4 pulse and verify spacing", gap_bad, 0);
    chk(vpp_bad == 0, "R11 writes only with vpp", vpp_bad, 0);
    mism = 0;
    for (int i = 0; i < exp_acc; i++) begin
      int a;
      logic [7:0] want;
      a = (sa + i) % 256;
      want = (exp_err && i == exp_acc - 1) ? 8'hFF : pat(a);
      if (mem[a] != want) mism++;
    end
    chk(mism == 0, "R5 programmed contents", mism, 0);
    if (hard_pos >= 0 && hard_pos < exp_acc)
      chk(pcount[hard] == ((nd > MP) ? MP : nd), "R6 pulses on hard byte",
          pcount[hard], (nd > MP) ? MP : nd);
    if (cnt == 0) chk(prog_total == 0, "R10 zero count writes nothing", prog_total, 0);
    repeat (5) @(negedge clk);
    chk(error == exp_err && (!exp_err || fail_addr == AW'(exp_fail)),
        "R9 error held while idle", int'(error), int'(exp_err));
  endtask

  initial begin
    bit seen;
    clear_model();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, error, src_ready, mem_vpp_en, mem_we, mem_rd} == 7'b0,
        "R1 reset outputs", int'({busy, done, error, src_ready, mem_vpp_en, mem_we, mem_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_vpp_en, "R1 idle after reset", int'(busy), 0);

    for (int v = 0; v < NV; v++)
      run_vec(int'(VECS[v][31:24]), int'(VECS[v][23:16]),
              int'(VECS[v][15:8]), int'(VECS[v][7:0]));

    // R2: a start during a run is ignored
    g_start = 8'h50; g_hard = 8'h51; g_need = 3;
    clear_model();
    feed_on = 1;
    launch(8'h50, 2);
    chk(mem_vpp_en == 1'b1, "R2 vpp raised at run start", int'(mem_vpp_en), 1);
    repeat (15) @(negedge clk);
    start = 1'b1; start_addr = 8'hA0; byte_count = 8'd3;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    feed_on = 0;
    @(negedge clk);
    chk(pcount[8'hA0] + pcount[8'hA1] + pcount[8'hA2] == 0, "R2 busy start ignored",
        pcount[8'hA0] + pcount[8'hA1] + pcount[8'hA2], 0);
    chk(mem[8'h50] == pat(8'h50) && mem[8'h51] == pat(8'h51), "R2 original run intact",
        int'(mem[8'h51]), int'(pat(8'h51)));
    chk(acc_cnt == 2, "R7 stream bytes after ignored start", acc_cnt, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule